// File: doc/BRIEF.md
# Two-Channel Redundant-Digit Code Combiner and Interleaver

This block sits behind two parallel two-stage pipeline converter channels and turns their raw stage decisions into one 6-bit output stream. Each channel delivers a 4-bit first-stage code (0..14) and a 3-bit second-stage code (0..7). For one sample, the second-stage code arrives one channel period (two full-rate cycles) after the first-stage code. The block holds each coarse code for one extra channel period so that it meets the fine code of the same sample. It then merges the pair with a one-bit overlap: the corrected word is 4×coarse + fine. The addition runs on a carry-lookahead adder, and the result is saturated at 63.

Both channels run at half the output rate. Everything is clocked at the full rate, and `ch_phase` tells which channel owns the current cycle. A channel takes its inputs only in the cycles it owns. The output register loads on every full-rate edge from the lane named by `ch_phase`. The output therefore alternates channel 0, channel 1, channel 0, and so on. A synchronous reset empties the pipeline. `out_valid` marks only those words whose coarse and fine codes were both presented with `in_valid` high.

Top module: `rsd_combiner`

## Requirements
- R1: In the first cycle after a reset edge, `out_valid` is 0 and `out_word` is 0.
- R2: A valid output word equals 4×C + F. C is the coarse code of a sample and F is the fine code presented for that sample one channel period later.
- R3: Whenever 4×C + F exceeds 63 (for example C=15 with F≥4), the word is clamped to 63.
- R4: An edge with `ch_phase`=0 loads the output from channel 0 and advances only channel 0; an edge with `ch_phase`=1 does the same for channel 1. A channel's input codes are ignored in cycles that it does not own. The bench drives `ch_phase`=0 on even cycles.
- R5: The coarse code is captured at edge t and the fine code at edge t+2. The merged word appears on the output right after edge t+4, so the total latency is five edges.
- R6: `out_valid` is 1 only if `in_valid` was high at both the coarse edge t and the fine edge t+2 of that sample.
- R7: After reset, `out_valid` stays 0 for at least the first four edges, even when the inputs are valid throughout.
- R8: The carry-lookahead sum equals the exact arithmetic sum of its two operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| ch_phase | input | 1 | Channel that owns the current cycle (0 or 1) |
| in_valid | input | 1 | Qualifies the codes presented in this cycle |
| coarse_in | input | 2×4 | First-stage code per channel, index = channel |
| fine_in | input | 2×3 | Second-stage code per channel, index = channel |
| out_word | output | 6 | Corrected, interleaved output word |
| out_valid | output | 1 | The word in `out_word` is valid |

## Verification
The hardest case to reach is a word whose coarse code was valid but whose fine code, presented two cycles later on the same channel, was not. The other channel keeps producing valid words in between, so the loss has to be attributed to the right sample. The stimulus table drops `in_valid` in a single cycle. That marks invalid both the sample whose fine code falls in that cycle and the sample whose coarse code falls in it, while the neighbouring samples stay valid. Saturation comes from table entries with a coarse code of 15. The unowned channel is fed inverted codes, so any leak between lanes corrupts the expected words.

// File: rtl/rsd_pkg.sv
package rsd_pkg;
    localparam int unsigned COARSE_W_DEF = 4;
    localparam int unsigned FINE_W_DEF   = 3;
    localparam int unsigned OUT_W_DEF    = 6;

    typedef enum logic {
        LANE_EVEN = 1'b0,
        LANE_ODD  = 1'b1
    } lane_sel_t;
endpackage

// File: rtl/rsd_cla.sv
module rsd_cla #(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s,
    output logic         cout
);
    logic [W-1:0] g;
    logic [W-1:0] p;
    logic [W:0]   c;

    assign g = a & b;
    assign p = a ^ b;

    // each carry is a flat sum of generate terms gated by propagate runs
    always_comb begin
        logic acc;
        logic term;
        c[0] = 1'b0;
        for (int i = 0; i < W; i++) begin
            acc = 1'b0;
            for (int j = 0; j <= i; j++) begin
                term = g[j];
                for (int k = j + 1; k <= i; k++) begin
                    term = term & p[k];
                end
                acc = acc | term;
            end
            c[i+1] = acc;
        end
    end

    assign s    = p ^ c[W-1:0];
    assign cout = c[W];

    AST_CLA_EXACT: assert property (@(posedge clk) disable iff (rst)
        {cout, s} == ({1'b0, a} + {1'b0, b})); // R8
endmodule

// File: rtl/rsd_lane.sv
module rsd_lane
    import rsd_pkg::*;
#(
    parameter int unsigned COARSE_W = COARSE_W_DEF,
    parameter int unsigned FINE_W   = FINE_W_DEF,
    parameter int unsigned OUT_W    = OUT_W_DEF,
    parameter lane_sel_t   LANE     = LANE_EVEN
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ch_phase,
    input  logic                in_valid,
    input  logic [COARSE_W-1:0] coarse,
    input  logic [FINE_W-1:0]   fine,
    output logic [OUT_W-1:0]    word,
    output logic                word_valid
);
    localparam int unsigned SHIFT = FINE_W - 1;
    localparam int unsigned SUM_W = COARSE_W + SHIFT + 1;
    localparam logic [SUM_W-1:0] OMAX = SUM_W'((1 << OUT_W) - 1);
    localparam logic [COARSE_W-1:0] CMAX = '1;

    logic                own;
    logic [COARSE_W-1:0] crs_q;
    logic                crs_v;
    logic [COARSE_W-1:0] crs_al;
    logic [FINE_W-1:0]   fin_q;
    logic                pair_v;
    logic [SUM_W-1:0]    op_a;
    logic [SUM_W-1:0]    op_b;
    logic [SUM_W-1:0]    raw_sum;
    logic                raw_co;
    logic [OUT_W-1:0]    clamped;
    logic [OUT_W-1:0]    sum_q;
    logic                sum_v;

    assign own  = (ch_phase == LANE);
    assign op_a = {1'b0, crs_al, {SHIFT{1'b0}}};
    assign op_b = SUM_W'(fin_q);

    rsd_cla #(.W(SUM_W)) u_cla (
        .clk (clk),
        .rst (rst),
        .a   (op_a),
        .b   (op_b),
        .s   (raw_sum),
        .cout(raw_co)
    );

    always_comb begin
        if (raw_co || (raw_sum > OMAX)) begin
            clamped = OMAX[OUT_W-1:0];
        end else begin
            clamped = raw_sum[OUT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            crs_q  <= '0;
            crs_v  <= 1'b0;
            crs_al <= '0;
            fin_q  <= '0;
            pair_v <= 1'b0;
            sum_q  <= '0;
            sum_v  <= 1'b0;
        end else begin
            if (own) begin
                crs_q  <= coarse;
                crs_v  <= in_valid;
                crs_al <= crs_q;
                fin_q  <= fine;
                pair_v <= crs_v & in_valid;
            end
            sum_q <= clamped;
            sum_v <= pair_v;
        end
    end

    assign word       = sum_q;
    assign word_valid = sum_v;

    AST_CLAMP_SAT: assert property (@(posedge clk) disable iff (rst)
        (crs_al == CMAX && fin_q[FINE_W-1]) |=> (sum_q == OMAX[OUT_W-1:0])); // R3
    AST_PAIR_NEEDS_COARSE: assert property (@(posedge clk) disable iff (rst)
        $rose(pair_v) |-> $past(crs_v)); // R6
endmodule

// File: rtl/rsd_combiner.sv
module rsd_combiner
    import rsd_pkg::*;
#(
    parameter int unsigned COARSE_W = COARSE_W_DEF,
    parameter int unsigned FINE_W   = FINE_W_DEF,
    parameter int unsigned OUT_W    = OUT_W_DEF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ch_phase,
    input  logic                     in_valid,
    input  logic [1:0][COARSE_W-1:0] coarse_in,
    input  logic [1:0][FINE_W-1:0]   fine_in,
    output logic [OUT_W-1:0]         out_word,
    output logic                     out_valid
);
    localparam int unsigned NCH = 2;

    logic [OUT_W-1:0] lane_word [NCH];
    logic             lane_v    [NCH];

    for (genvar k = 0; k < NCH; k++) begin : g_lane
        rsd_lane #(
            .COARSE_W(COARSE_W),
            .FINE_W  (FINE_W),
            .OUT_W   (OUT_W),
            .LANE    (lane_sel_t'(k))
        ) u_lane (
            .clk       (clk),
            .rst       (rst),
            .ch_phase  (ch_phase),
            .in_valid  (in_valid),
            .coarse    (coarse_in[k]),
            .fine      (fine_in[k]),
            .word      (lane_word[k]),
            .word_valid(lane_v[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_word  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_word  <= lane_word[ch_phase];
            out_valid <= lane_v[ch_phase];
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && out_word == '0)); // R1
    AST_EVEN_FROM_LANE0: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ch_phase) == 1'b0) |-> (out_word == $past(lane_word[0]))); // R4
    AST_ODD_FROM_LANE1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ch_phase) == 1'b1) |-> (out_word == $past(lane_word[1]))); // R4
    AST_VALID_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(in_valid, 3) && $past(in_valid, 5))); // R6
endmodule

// File: tb/sim_rsd_combiner.sv
module sim_rsd_combiner;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic            rst;
    logic            ch_phase;
    logic            in_valid;
    logic [1:0][3:0] coarse_in;
    logic [1:0][2:0] fine_in;
    logic [5:0]      out_word;
    logic            out_valid;

    int errs   = 0;
    int checks = 0;

    rsd_combiner u0 (
        .clk      (clk),
        .rst      (rst),
        .ch_phase (ch_phase),
        .in_valid (in_valid),
        .coarse_in(coarse_in),
        .fine_in  (fine_in),
        .out_word (out_word),
        .out_valid(out_valid)
    );

    // {valid, coarse, fine, expected word}
    localparam int N = 16;
    localparam logic [13:0] VEC [N] = '{
        {1'b1, 4'd0,  3'd0, 6'd0},
        {1'b1, 4'd14, 3'd7, 6'd63},
        {1'b1, 4'd5,  3'd3, 6'd23},
        {1'b1, 4'd7,  3'd2, 6'd30},
        {1'b1, 4'd15, 3'd7, 6'd63},
        {1'b1, 4'd15, 3'd4, 6'd63},
        {1'b1, 4'd15, 3'd3, 6'd63},
        {1'b1, 4'd1,  3'd1, 6'd5},
        {1'b0, 4'd9,  3'd6, 6'd42},
        {1'b1, 4'd2,  3'd7, 6'd15},
        {1'b1, 4'd10, 3'd0, 6'd40},
        {1'b1, 4'd3,  3'd5, 6'd17},
        {1'b1, 4'd12, 3'd6, 6'd54},
        {1'b1, 4'd4,  3'd4, 6'd20},
        {1'b1, 4'd6,  3'd1, 6'd25},
        {1'b1, 4'd11, 3'd7, 6'd51}
    };

    task automatic chk(input string tag, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    // drive both lanes with the same codes
    task automatic drive_both(input int i, input logic [3:0] c, input logic [2:0] f, input logic v);
        ch_phase     = i[0];
        in_valid     = v;
        coarse_in[0] = c;
        coarse_in[1] = c;
        fine_in[0]   = f;
        fine_in[1]   = f;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 valid", {6'd0, out_valid}, 7'd0);
        chk("R1 word", {1'b0, out_word}, 7'd0);
        rst = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        errs++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        report();
    end

    initial begin
        rst       = 1'b1;
        ch_phase  = 1'b0;
        in_valid  = 1'b0;
        coarse_in = '0;
        fine_in   = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        do_reset();

        // table walk: channel i%2 owns cycle i, other channel gets inverted codes
        for (int i = 0; i < N + 5; i++) begin
            logic       ph;
            logic       ev;
            int         t;
            if (i < 5) begin
                chk("R7 fill", {6'd0, out_valid}, 7'd0);
            end else begin
                t  = i - 5;
                ev = VEC[t][13] && ((t + 2 < N) ? VEC[t+2][13] : 1'b1);
                chk("R6 valid", {6'd0, out_valid}, {6'd0, ev});
                if (ev) chk("R2 R3 R4 R5 R8 word", {1'b0, out_word}, {1'b0, VEC[t][5:0]});
            end
            ph            = i[0];
            ch_phase      = ph;
            in_valid      = (i < N) ? VEC[i][13] : 1'b1;
            coarse_in[ph] = (i < N) ? VEC[i][12:9] : 4'd0;
            fine_in[ph]   = (i >= 2 && i - 2 < N) ? VEC[i-2][8:6] : 3'd0;
            coarse_in[~ph] = ~coarse_in[ph];
            fine_in[~ph]   = ~fine_in[ph];
            @(negedge clk);
        end

        // mid-stream reset, then latency with constant codes
        do_reset();
        for (int i = 0; i < 9; i++) begin
            if (i < 5) begin
                chk("R7 after reset", {6'd0, out_valid}, 7'd0);
            end else begin
                chk("R5 valid", {6'd0, out_valid}, 7'd1);
                chk("R5 word", {1'b0, out_word}, 7'd58);
            end
            drive_both(i, 4'd13, 3'd6, 1'b1);
            @(negedge clk);
        end

        // in_valid dropped in cycle 2 only
        do_reset();
        for (int i = 0; i < 10; i++) begin
            int   t;
            logic ev;
            if (i >= 5) begin
                t  = i - 5;
                ev = (t != 0) && (t != 2);
                chk("R6 dropped", {6'd0, out_valid}, {6'd0, ev});
                if (ev) chk("R2 word", {1'b0, out_word}, 7'd9);
            end
            drive_both(i, 4'd2, 3'd1, (i != 2));
            @(negedge clk);
        end

        report();
    end
endmodule